// File: doc/BRIEF.md
# Warp-Type Aware Cache Bank Controller

This block manages the tags and the replacement order for one bank of a set-associative shared cache. It keeps a true least-recently-used order in each set. Every lookup request and every line fill carries the warp type of the thread group that issued it. The warp type decides two things. First, it decides whether a request looks in the cache at all or goes straight to memory. Second, it decides whether a returning line joins its set at the most-recently-used (MRU) end or the least-recently-used (LRU) end of the recency order.

Warps that rarely hit skip the bank entirely, which keeps them out of the bank queue. Their lines can still be cached, but they enter at the eviction end. Such a line stays resident only if some other warp touches it before the next eviction from that set. The block holds no data. It produces a hit or miss flag, a bypass flag, the way that hit, and a strobe that forwards the request to memory.

Top module: `wtc_bank_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `rsp_vld`, `rsp_hit`, `rsp_bypass`, `mem_fwd` and `rsp_way` are 0 and every line is invalid, so the first normal lookup to any set misses.
- R2: Warp-type codes are 0 all-hit, 1 mostly-hit, 2 balanced, 3 mostly-miss and 4 all-miss; codes 5 to 7 behave as balanced. For a request of type 3 or 4 the response has `rsp_bypass`=1, `rsp_hit`=0 and `mem_fwd`=1. Such a request leaves the recency order unchanged, even when its tag is resident.
- R3: A request of type 0, 1 or 2 looks up the set. On a hit the response has `rsp_hit`=1, `rsp_way` set to the way that hit, and `mem_fwd`=0. On a miss it has `rsp_hit`=0 and `mem_fwd`=1.
- R4: `rsp_vld` is 1 in exactly the cycle after an accepted request. `rsp_hit`, `rsp_bypass` and `mem_fwd` are 0 whenever `rsp_vld` is 0.
- R5: A fill of type 0, 1 or 2 places its tag in the lowest-numbered invalid way of the set, if there is one, and makes that line MRU.
- R6: A fill of type 3 or 4 is allocated at the LRU position when parameter `ALLOC_MISS_FILL` is 1. When it is 0, such a fill is not allocated.
- R7: A lookup hit moves the line to MRU. Lines that were more recent than it move one step toward LRU.
- R8: When every way of the set is valid, a fill evicts the way that holds the LRU position.
- R9: When `fill_vld` and `req_vld` are both 1 in the same cycle, the fill is performed and the request is dropped, with no response.
- R10: A fill whose tag is already resident in the set changes neither the tags nor the recency order.
- R11: A line inserted at LRU that a normal-type request then hits is promoted to MRU and outlives the next eviction from its set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld | input | 1 | Lookup request valid |
| req_set | input | SET_W | Set index of the request |
| req_tag | input | TAG_W | Tag of the request |
| req_wtype | input | 3 | Warp type of the requester |
| fill_vld | input | 1 | Line fill valid |
| fill_set | input | SET_W | Set index of the fill |
| fill_tag | input | TAG_W | Tag of the filled line |
| fill_wtype | input | 3 | Warp type the fill was fetched for |
| rsp_vld | output | 1 | Response valid, one cycle after the request |
| rsp_hit | output | 1 | Lookup hit |
| rsp_bypass | output | 1 | Request bypassed the cache |
| rsp_way | output | WAY_W | Way that hit, 0 otherwise |
| mem_fwd | output | 1 | Forward the request to memory |

## Verification
On every cycle, the assertions check the consistency of the response flags and their one-cycle timing:
- bypass and hit are never both 1;
- a miss always forwards to memory;
- an idle cycle produces no strobe;
- a dropped request gives no response;
- the bypass decision follows the warp type of the request.

Other behaviours show only across several operations, so only the bench scenarios can demonstrate them. These are the recency order, the choice of victim, insertion at MRU or LRU, promotion of lines inserted at LRU, and the effect of the allocation parameter on bypassed fills. The bench drives sequences of fills and lookups and checks which tags survive later evictions.

// File: rtl/wtc_pkg.sv
// Package: shared warp-type codes and classification helper for the
// warp-type aware cache bank controller.
package wtc_pkg;

    typedef enum logic [2:0] {
        WT_ALL_HIT     = 3'd0,
        WT_MOSTLY_HIT  = 3'd1,
        WT_BALANCED    = 3'd2,
        WT_MOSTLY_MISS = 3'd3,
        WT_ALL_MISS    = 3'd4
    } wtype_e;

    // True for the two warp types that skip the cache and insert at LRU.
    function automatic logic wt_is_miss(input logic [2:0] wt);
        return (wt == WT_MOSTLY_MISS) || (wt == WT_ALL_MISS);
    endfunction

endpackage

// File: rtl/wtc_policy.sv
// Module: wtc_policy
// Maps a warp type onto the three policy decisions of the bank:
// whether to skip the lookup, whether a fill goes in at LRU, and
// whether a fill may be allocated at all.
// Assumes codes 5..7 are treated as balanced (normal) warps.
module wtc_policy #(
    parameter bit ALLOC_MISS_FILL = 1'b1
) (
    input  logic [2:0] wtype,
    output logic       bypass,
    output logic       ins_lru,
    output logic       alloc_ok
);
    import wtc_pkg::*;

    // Combinational type decode.
    always_comb begin
        bypass   = wt_is_miss(wtype);
        ins_lru  = wt_is_miss(wtype);
        alloc_ok = !wt_is_miss(wtype) || ALLOC_MISS_FILL;
    end

endmodule

// File: rtl/wtc_tag_store.sv
// Module: wtc_tag_store
// Holds tag and valid bits for every way of every set. Provides two
// read ports (lookup, fill duplicate check) and one write port.
// Assumes the caller never writes a tag already present in the set.
module wtc_tag_store #(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int TAG_W = 8,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic [WAYS-1:0]  lk_hit_vec,
    input  logic [SET_W-1:0] fl_set,
    input  logic [TAG_W-1:0] fl_tag,
    output logic [WAYS-1:0]  fl_hit_vec,
    output logic [WAYS-1:0]  fl_valid_vec,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [WAY_W-1:0] wr_way,
    input  logic [TAG_W-1:0] wr_tag
);
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [WAYS-1:0]  valid_q [SETS];

    // Per-way tag compare for both read ports.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign lk_hit_vec[w] = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
        assign fl_hit_vec[w] = valid_q[fl_set][w] && (tag_q[fl_set][w] == fl_tag);
    end

    assign fl_valid_vec = valid_q[fl_set];

    // Valid bits: cleared on reset, set on allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else if (wr_en) begin
            valid_q[wr_set][wr_way] <= 1'b1;
        end
    end

    // Tag array: written on allocation, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_set][wr_way] <= wr_tag;
    end

endmodule

// File: rtl/wtc_rank.sv
// Module: wtc_rank
// True-LRU state as a per-set rank for each way (0 = MRU, WAYS-1 = LRU).
// The ranks of a set always form a permutation. Picks the victim (lowest
// invalid way first, else the LRU way) and applies a single-cycle move to
// MRU or to LRU.
module wtc_rank #(
    parameter int SETS = 16,
    parameter int WAYS = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] vic_set,
    input  logic [WAYS-1:0]  vic_valid_vec,
    output logic [WAY_W-1:0] vic_way,
    input  logic             upd_en,
    input  logic [SET_W-1:0] upd_set,
    input  logic [WAY_W-1:0] upd_way,
    input  logic             upd_lru
);
    localparam logic [WAY_W-1:0] LRU_RANK = WAY_W'(WAYS - 1);

    logic [WAY_W-1:0] rank_q [SETS][WAYS];
    logic [WAY_W-1:0] old_rank;
    logic             inv_found;

    assign old_rank = rank_q[upd_set][upd_way];

    // Victim choice: lowest invalid way, otherwise the LRU-ranked way.
    always_comb begin
        vic_way   = '0;
        inv_found = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!inv_found && !vic_valid_vec[w]) begin
                vic_way   = WAY_W'(w);
                inv_found = 1'b1;
            end
        end
        if (!inv_found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (rank_q[vic_set][w] == LRU_RANK) vic_way = WAY_W'(w);
            end
        end
    end

    // Rank update: identity on reset, move-to-MRU or move-to-LRU otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    rank_q[s][w] <= WAY_W'(w);
        end else if (upd_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == upd_way) begin
                    rank_q[upd_set][w] <= upd_lru ? LRU_RANK : '0;
                end else if (!upd_lru && rank_q[upd_set][w] < old_rank) begin
                    rank_q[upd_set][w] <= rank_q[upd_set][w] + 1'b1;
                end else if (upd_lru && rank_q[upd_set][w] > old_rank) begin
                    rank_q[upd_set][w] <= rank_q[upd_set][w] - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/wtc_bank_ctrl.sv
// Module: wtc_bank_ctrl (top)
// Tag and replacement controller for one bank of a shared cache with
// warp-type aware bypass and insertion. A request is accepted only when
// no fill is presented in the same cycle. Responses are registered and
// appear one cycle after acceptance.
module wtc_bank_ctrl #(
    parameter int SETS            = 16,
    parameter int WAYS            = 4,
    parameter int TAG_W           = 8,
    parameter bit ALLOC_MISS_FILL = 1'b1,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_vld,
    input  logic [SET_W-1:0] req_set,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [2:0]       req_wtype,
    input  logic             fill_vld,
    input  logic [SET_W-1:0] fill_set,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [2:0]       fill_wtype,
    output logic             rsp_vld,
    output logic             rsp_hit,
    output logic             rsp_bypass,
    output logic [WAY_W-1:0] rsp_way,
    output logic             mem_fwd
);
    logic             req_byp, req_ins_lru_unused, req_alloc_unused;
    logic             fill_byp_unused, fill_ins_lru, fill_alloc_ok;
    logic [WAYS-1:0]  lk_hit_vec, fl_hit_vec, fl_valid_vec;
    logic [WAY_W-1:0] hit_way, vic_way;
    logic             accept, do_hit, fill_alloc;
    logic             upd_en, upd_lru;
    logic [SET_W-1:0] upd_set;
    logic [WAY_W-1:0] upd_way;

    wtc_policy #(.ALLOC_MISS_FILL(ALLOC_MISS_FILL)) u_req_pol (
        .wtype    (req_wtype),
        .bypass   (req_byp),
        .ins_lru  (req_ins_lru_unused),
        .alloc_ok (req_alloc_unused)
    );

    wtc_policy #(.ALLOC_MISS_FILL(ALLOC_MISS_FILL)) u_fill_pol (
        .wtype    (fill_wtype),
        .bypass   (fill_byp_unused),
        .ins_lru  (fill_ins_lru),
        .alloc_ok (fill_alloc_ok)
    );

    wtc_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
        .clk          (clk),
        .rst_n        (rst_n),
        .lk_set       (req_set),
        .lk_tag       (req_tag),
        .lk_hit_vec   (lk_hit_vec),
        .fl_set       (fill_set),
        .fl_tag       (fill_tag),
        .fl_hit_vec   (fl_hit_vec),
        .fl_valid_vec (fl_valid_vec),
        .wr_en        (fill_alloc),
        .wr_set       (fill_set),
        .wr_way       (vic_way),
        .wr_tag       (fill_tag)
    );

    wtc_rank #(.SETS(SETS), .WAYS(WAYS)) u_rank (
        .clk           (clk),
        .rst_n         (rst_n),
        .vic_set       (fill_set),
        .vic_valid_vec (fl_valid_vec),
        .vic_way       (vic_way),
        .upd_en        (upd_en),
        .upd_set       (upd_set),
        .upd_way       (upd_way),
        .upd_lru       (upd_lru)
    );

    // Encode the hitting way (tags are unique within a set).
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (lk_hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    // Accept, hit and allocation decisions.
    always_comb begin
        accept     = req_vld && !fill_vld;
        do_hit     = accept && !req_byp && (|lk_hit_vec);
        fill_alloc = fill_vld && fill_alloc_ok && !(|fl_hit_vec);
    end

    // Recency update port: a fill has priority over a lookup hit.
    always_comb begin
        upd_en  = fill_alloc || do_hit;
        upd_set = fill_alloc ? fill_set : req_set;
        upd_way = fill_alloc ? vic_way : hit_way;
        upd_lru = fill_alloc && fill_ins_lru;
    end

    // Registered response toward the requester and memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld    <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_bypass <= 1'b0;
            rsp_way    <= '0;
            mem_fwd    <= 1'b0;
        end else begin
            rsp_vld    <= accept;
            rsp_hit    <= do_hit;
            rsp_bypass <= accept && req_byp;
            rsp_way    <= do_hit ? hit_way : '0;
            mem_fwd    <= accept && !do_hit;
        end
    end

endmodule

// File: rtl/wtc_bank_ctrl_chk.sv
// Module: wtc_bank_ctrl_chk
// Port-level protocol checks for wtc_bank_ctrl, attached by bind.
module wtc_bank_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_vld,
    input logic [2:0] req_wtype,
    input logic       fill_vld,
    input logic       rsp_vld,
    input logic       rsp_hit,
    input logic       rsp_bypass,
    input logic       mem_fwd
);
    import wtc_pkg::*;

    AST_BYP_NEVER_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_bypass |-> !rsp_hit);                                            // R2
    AST_MISS_TYPE_BYPASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !fill_vld && wt_is_miss(req_wtype)) |=> (rsp_vld && rsp_bypass && mem_fwd)); // R2
    AST_NORMAL_TYPE_LOOKS_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !fill_vld && !wt_is_miss(req_wtype)) |=> (rsp_vld && !rsp_bypass)); // R3
    AST_MISS_FORWARDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && !rsp_hit) |-> mem_fwd);                                  // R3
    AST_HIT_NO_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> !mem_fwd);                                               // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_vld |-> (!rsp_hit && !rsp_bypass && !mem_fwd));                 // R4
    AST_NO_REQ_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !rsp_vld);                                              // R4
    AST_FILL_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        fill_vld |=> !rsp_vld);                                              // R9

endmodule

bind wtc_bank_ctrl wtc_bank_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_vld    (req_vld),
    .req_wtype  (req_wtype),
    .fill_vld   (fill_vld),
    .rsp_vld    (rsp_vld),
    .rsp_hit    (rsp_hit),
    .rsp_bypass (rsp_bypass),
    .mem_fwd    (mem_fwd)
);

// File: tb/wtc_bank_ctrl_bench.sv
// Bench for wtc_bank_ctrl: a vector table walked by one loop, then directed
// tests for reset, fill/request collision and the no-allocate variant.
module wtc_bank_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_vld = 1'b0;
    logic [3:0] req_set = '0;
    logic [7:0] req_tag = '0;
    logic [2:0] req_wtype = '0;
    logic       fill_vld = 1'b0;
    logic [3:0] fill_set = '0;
    logic [7:0] fill_tag = '0;
    logic [2:0] fill_wtype = '0;
    logic       rsp_vld, rsp_hit, rsp_bypass, mem_fwd;
    logic [1:0] rsp_way;
    logic       na_vld, na_hit, na_bypass, na_fwd;
    logic [1:0] na_way;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    wtc_bank_ctrl u_wtc_bank_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_vld(req_vld), .req_set(req_set), .req_tag(req_tag), .req_wtype(req_wtype),
        .fill_vld(fill_vld), .fill_set(fill_set), .fill_tag(fill_tag), .fill_wtype(fill_wtype),
        .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_bypass(rsp_bypass),
        .rsp_way(rsp_way), .mem_fwd(mem_fwd)
    );

    wtc_bank_ctrl #(.ALLOC_MISS_FILL(1'b0)) u_wtc_bank_ctrl_na (
        .clk(clk), .rst_n(rst_n),
        .req_vld(req_vld), .req_set(req_set), .req_tag(req_tag), .req_wtype(req_wtype),
        .fill_vld(fill_vld), .fill_set(fill_set), .fill_tag(fill_tag), .fill_wtype(fill_wtype),
        .rsp_vld(na_vld), .rsp_hit(na_hit), .rsp_bypass(na_bypass),
        .rsp_way(na_way), .mem_fwd(na_fwd)
    );

    typedef struct packed {
        logic       is_fill;
        logic [3:0] set;
        logic [7:0] tag;
        logic [2:0] wt;
        logic       e_hit;
        logic       e_byp;
        logic       e_fwd;
        logic [1:0] e_way;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 4'd3, 8'h10, 3'd0, 1'b0, 1'b0, 1'b1, 2'd0}, // R1 R3 cold miss
        '{1'b1, 4'd3, 8'h10, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0}, // R5 way0
        '{1'b1, 4'd3, 8'h11, 3'd1, 1'b0, 1'b0, 1'b0, 2'd0}, // R5 way1
        '{1'b1, 4'd3, 8'h12, 3'd2, 1'b0, 1'b0, 1'b0, 2'd0}, // R5 way2
        '{1'b1, 4'd3, 8'h13, 3'd3, 1'b0, 1'b0, 1'b0, 2'd0}, // R6 way3 at LRU
        '{1'b0, 4'd3, 8'h13, 3'd4, 1'b0, 1'b1, 1'b1, 2'd0}, // R2 bypass, resident
        '{1'b0, 4'd3, 8'h10, 3'd0, 1'b1, 1'b0, 1'b0, 2'd0}, // R3 R7 hit way0
        '{1'b1, 4'd3, 8'h14, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0}, // R8 evicts 0x13
        '{1'b0, 4'd3, 8'h13, 3'd0, 1'b0, 1'b0, 1'b1, 2'd0}, // R6 R8 LRU line gone
        '{1'b1, 4'd3, 8'h15, 3'd4, 1'b0, 1'b0, 1'b0, 2'd0}, // R6 LRU fill way1
        '{1'b0, 4'd3, 8'h15, 3'd1, 1'b1, 1'b0, 1'b0, 2'd1}, // R11 promote
        '{1'b1, 4'd3, 8'h16, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0}, // R8 evicts 0x12
        '{1'b0, 4'd3, 8'h15, 3'd2, 1'b1, 1'b0, 1'b0, 2'd1}, // R11 survived
        '{1'b0, 4'd3, 8'h12, 3'd0, 1'b0, 1'b0, 1'b1, 2'd0}, // R8 victim was LRU
        '{1'b1, 4'd3, 8'h10, 3'd1, 1'b0, 1'b0, 1'b0, 2'd0}, // R10 duplicate fill
        '{1'b1, 4'd3, 8'h17, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0}, // R10 evicts 0x10
        '{1'b0, 4'd3, 8'h10, 3'd0, 1'b0, 1'b0, 1'b1, 2'd0}, // R10 0x10 stayed LRU
        '{1'b0, 4'd3, 8'h17, 3'd0, 1'b1, 1'b0, 1'b0, 2'd0}, // R5 new line way0
        '{1'b0, 4'd3, 8'h14, 3'd5, 1'b1, 1'b0, 1'b0, 2'd3}, // R2 code5 normal
        '{1'b0, 4'd7, 8'h10, 3'd0, 1'b0, 1'b0, 1'b1, 2'd0}  // R3 other set
    };

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic idle();
        req_vld  = 1'b0;
        fill_vld = 1'b0;
    endtask

    task automatic drive_req(input logic [3:0] s, input logic [7:0] t, input logic [2:0] w);
        @(negedge clk);
        fill_vld = 1'b0;
        req_vld = 1'b1; req_set = s; req_tag = t; req_wtype = w;
        @(negedge clk);
        idle();
    endtask

    task automatic drive_fill(input logic [3:0] s, input logic [7:0] t, input logic [2:0] w);
        @(negedge clk);
        req_vld = 1'b0;
        fill_vld = 1'b1; fill_set = s; fill_tag = t; fill_wtype = w;
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        chk("R1", "rsp_vld in reset", rsp_vld, 0);
        chk("R1", "mem_fwd in reset", mem_fwd, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (TBL[i].is_fill) begin
                drive_fill(TBL[i].set, TBL[i].tag, TBL[i].wt);
            end else begin
                drive_req(TBL[i].set, TBL[i].tag, TBL[i].wt);
                chk("R4", $sformatf("row%0d rsp_vld", i), rsp_vld, 1);
                chk("R3", $sformatf("row%0d hit", i), rsp_hit, TBL[i].e_hit);
                chk("R2", $sformatf("row%0d bypass", i), rsp_bypass, TBL[i].e_byp);
                chk("R3", $sformatf("row%0d mem_fwd", i), mem_fwd, TBL[i].e_fwd);
                chk("R7", $sformatf("row%0d way", i), rsp_way, TBL[i].e_way);
            end
        end

        // R4: an idle cycle gives no response
        @(negedge clk);
        chk("R4", "idle rsp_vld", rsp_vld, 0);
        chk("R4", "idle mem_fwd", mem_fwd, 0);

        // R9: fill and request together, request dropped, fill done
        @(negedge clk);
        req_vld = 1'b1; req_set = 4'd3; req_tag = 8'h17; req_wtype = 3'd0;
        fill_vld = 1'b1; fill_set = 4'd5; fill_tag = 8'h30; fill_wtype = 3'd0;
        @(negedge clk);
        idle();
        chk("R9", "collision rsp_vld", rsp_vld, 0);
        drive_req(4'd5, 8'h30, 3'd0);
        chk("R9", "fill performed hit", rsp_hit, 1);

        // R1: reset clears the lines
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "rsp_vld after reset", rsp_vld, 0);
        chk("R1", "rsp_way after reset", rsp_way, 0);
        rst_n = 1'b1;
        drive_req(4'd3, 8'h17, 3'd0);
        chk("R1", "lookup after reset hit", rsp_hit, 0);
        chk("R1", "lookup after reset fwd", mem_fwd, 1);

        // R6: miss-type fill, allocated vs not allocated
        drive_fill(4'd0, 8'h20, 3'd3);
        drive_req(4'd0, 8'h20, 3'd0);
        chk("R6", "alloc variant hit", rsp_hit, 1);
        chk("R6", "no-alloc variant hit", na_hit, 0);
        chk("R6", "no-alloc variant fwd", na_fwd, 1);
        drive_fill(4'd0, 8'h21, 3'd1);
        drive_req(4'd0, 8'h21, 3'd1);
        chk("R5", "no-alloc normal fill hit", na_hit, 1);
        chk("R5", "no-alloc normal fill way", na_way, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule